// File: doc/BRIEF.md
# CAN Error-State Change Interrupt Filter

This block sits beside a CAN error-counter unit. It watches the two error-confinement states that unit reports, one for the transmitter and one for the receiver. When a state moves, the block decides whether the move matters. Each direction has its own 2-bit sensitivity code, and only moves that pass that code raise a status-change pending flag. The host clears the flag by writing one to it.

The block also gives the host two 2-bit status fields that mirror the actual states. These fields stop following the states while the pending flag is set, so the host reads the state that caused the interrupt. The interrupt-enable register holds the status-change enable, the overrun enable, the receive-full enable and both sensitivity codes. That register is forced to zero while the controller is in initialization mode.

Top module: `can_esf_top`

## Requirements
- R1: With a sensitivity code of 00, no state change in that direction sets the pending flag.
- R2: With code 01, a change sets the pending flag only if the old or the new state is bus-off (state encoding 00 = error-active, 01 = warning, 10 = error-passive, 11 = bus-off).
- R3: With code 10, a change sets the pending flag only if the old or the new state is warning (01) or bus-off (11).
- R4: With code 11, every change of state sets the pending flag.
- R5: The transmitter code is enable-register bits [3:2] and the receiver code is bits [5:4]. Each code filters only its own direction.
- R6: The pending flag is set on the clock edge after a change that passes the filter. Writing 1 to bit 0 at address 1 clears it, and writing 0 there has no effect. A pass and a clear in the same cycle leave the flag set.
- R7: While the flag is clear, each status field takes the input state one clock later. While the flag is set, both status fields hold their value.
- R8: `chg_irq` is high only when the pending flag and enable bit 6 are both high.
- R9: `ovr_irq` follows `ovr_flag` only while enable bit 1 is set. `rxf_irq` follows `rxf_flag` only while enable bit 0 is set.
- R10: While `init_req` and `init_ack` are both high, the enable register (address 0) is forced to zero and ignores writes. Once they are released, it accepts writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 = enable register, 1 = flag register |
| wr_data | input | 8 | Host write data |
| tx_state | input | 2 | Transmitter error state from the counter unit |
| rx_state | input | 2 | Receiver error state from the counter unit |
| ovr_flag | input | 1 | Overrun condition |
| rxf_flag | input | 1 | Receive-buffer-full condition |
| ien_rd | output | 8 | Enable register readback |
| tx_stat | output | 2 | Transmitter status field |
| rx_stat | output | 2 | Receiver status field |
| chg_pend | output | 1 | Status-change pending flag |
| chg_irq | output | 1 | Status-change interrupt request |
| ovr_irq | output | 1 | Overrun interrupt request |
| rxf_irq | output | 1 | Receive-full interrupt request |

## Verification
Some rules hold on every cycle, and the assertions check them there. A code of 00 never passes a change, and a code of 01 passes only moves that touch bus-off. A filter pass always leaves the flag set one cycle later. The status fields either hold under a pending flag or track the inputs one cycle late, and initialization always empties the enable register. Other behaviour needs a planned sequence of steps, so only the bench scenarios can show it. These are the full pass/reject pattern of each code across chosen walks through the four states, the independence of the two directions, a flag that survives a write of zero and a same-cycle clear, and the frozen field catching up after the clear.

// File: rtl/can_esf_pkg.sv
package can_esf_pkg;

  typedef logic [1:0] err_st_t;

  localparam err_st_t ST_ACTIVE  = 2'b00;
  localparam err_st_t ST_WARN    = 2'b01;
  localparam err_st_t ST_PASSIVE = 2'b10;
  localparam err_st_t ST_BUSOFF  = 2'b11;

  // Decide whether a move prv -> cur passes a sensitivity code.
  function automatic logic sens_hit(input logic [1:0] code,
                                    input err_st_t prv,
                                    input err_st_t cur);
    logic moved;
    logic busoff_edge;
    logic warn_edge;
    moved       = (prv != cur);
    busoff_edge = (prv == ST_BUSOFF) || (cur == ST_BUSOFF);
    // warning (01) and bus-off (11) share bit 0 set
    warn_edge   = prv[0] || cur[0];
    case (code)
      2'b00:   sens_hit = 1'b0;
      2'b01:   sens_hit = moved && busoff_edge;
      2'b10:   sens_hit = moved && warn_edge;
      default: sens_hit = moved;
    endcase
  endfunction

endpackage

// File: rtl/esf_dir_filter.sv
module esf_dir_filter
  import can_esf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  err_st_t    cur,
  output logic       hit
);

  err_st_t prv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prv_q <= ST_ACTIVE;
    else        prv_q <= cur;
  end

  assign hit = sens_hit(code, prv_q, cur);

  // R1: code 00 never passes a change
  a_r1_code_off: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b00) |-> !hit);

  // R2: code 01 passes only moves touching bus-off
  a_r2_busoff_only: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b01 && hit) |-> (prv_q == ST_BUSOFF || cur == ST_BUSOFF));

endmodule

// File: rtl/esf_ien_reg.sv
module esf_ien_reg #(
  parameter int IEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_init,
  input  logic             wr,
  input  logic [IEN_W-1:0] wdata,
  output logic [IEN_W-1:0] ien_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || in_init) ien_q <= '0;
    else if (wr)           ien_q <= wdata;
  end

  // R10: initialization mode empties the register
  a_r10_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_init |=> (ien_q == '0));

endmodule

// File: rtl/esf_status.sv
module esf_status
  import can_esf_pkg::*;
#(
  parameter int NDIR = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NDIR-1:0]      hit,
  input  logic                 clr,
  input  logic [NDIR-1:0][1:0] cur,
  output logic                 pend,
  output logic [NDIR-1:0][1:0] stat
);

  logic any_hit;
  assign any_hit = |hit;

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (any_hit) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     stat <= '0;
    else if (!pend) stat <= cur;
  end

  // R6: a filter pass leaves the flag set
  a_r6_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> pend);

  // R7: fields frozen while pending
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable(stat));

  // R7: fields track the inputs one cycle late when not pending
  a_r7_track: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> (stat == $past(cur)));

endmodule

// File: rtl/can_esf_top.sv
module can_esf_top
  import can_esf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  input  logic          init_ack,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    tx_state,
  input  logic [1:0]    rx_state,
  input  logic          ovr_flag,
  input  logic          rxf_flag,
  output logic [DW-1:0] ien_rd,
  output logic [1:0]    tx_stat,
  output logic [1:0]    rx_stat,
  output logic          chg_pend,
  output logic          chg_irq,
  output logic          ovr_irq,
  output logic          rxf_irq
);

  localparam int NDIR   = 2;
  localparam int IEN_W  = 7;
  localparam int B_RXF  = 0;
  localparam int B_OVR  = 1;
  localparam int B_TXS  = 2;
  localparam int B_RXS  = 4;
  localparam int B_CHG  = 6;

  logic                 in_init;
  logic [IEN_W-1:0]     ien_q;
  logic [NDIR-1:0][1:0] sens;
  logic [NDIR-1:0][1:0] cur;
  logic [NDIR-1:0][1:0] stat;
  logic [NDIR-1:0]      hit;
  logic                 clr;

  assign in_init = init_req && init_ack;
  assign clr     = wr_en && wr_addr && wr_data[0];

  esf_ien_reg #(.IEN_W(IEN_W)) u_ien (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_init (in_init),
    .wr      (wr_en && !wr_addr),
    .wdata   (wr_data[IEN_W-1:0]),
    .ien_q   (ien_q)
  );

  assign sens[0] = ien_q[B_TXS +: 2];
  assign sens[1] = ien_q[B_RXS +: 2];
  assign cur[0]  = tx_state;
  assign cur[1]  = rx_state;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    esf_dir_filter u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (sens[g]),
      .cur   (cur[g]),
      .hit   (hit[g])
    );
  end

  esf_status #(.NDIR(NDIR)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (hit),
    .clr  (clr),
    .cur  (cur),
    .pend (chg_pend),
    .stat (stat)
  );

  assign tx_stat = stat[0];
  assign rx_stat = stat[1];
  assign ien_rd  = DW'(ien_q);
  assign chg_irq = chg_pend && ien_q[B_CHG];
  assign ovr_irq = ovr_flag && ien_q[B_OVR];
  assign rxf_irq = rxf_flag && ien_q[B_RXF];

  // R8: no status-change request without a pending flag
  a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    chg_irq |-> chg_pend);

  // R9: no overrun request without the overrun condition
  a_r9_ovr_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> ovr_flag);

endmodule

// File: tb/sim_can_esf_top.sv
`timescale 1ns/1ps
module sim_can_esf_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_req = 1'b0, init_ack = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] tx_state = '0, rx_state = '0;
  logic       ovr_flag = 1'b0, rxf_flag = 1'b0;
  logic [7:0] ien_rd;
  logic [1:0] tx_stat, rx_stat;
  logic       chg_pend, chg_irq, ovr_irq, rxf_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  can_esf_top u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_state(tx_state), .rx_state(rx_state),
    .ovr_flag(ovr_flag), .rxf_flag(rxf_flag),
    .ien_rd(ien_rd), .tx_stat(tx_stat), .rx_stat(rx_stat),
    .chg_pend(chg_pend), .chg_irq(chg_irq), .ovr_irq(ovr_irq), .rxf_irq(rxf_irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // drive one direction to nv; expected flag result; status must track
  task automatic step(input bit is_rx, input logic [1:0] nv, input bit exp, input string tag);
    @(negedge clk);
    if (is_rx) rx_state = nv; else tx_state = nv;
    @(negedge clk);
    chk({7'd0, chg_pend}, {7'd0, exp}, tag);
    chk({6'd0, (is_rx ? rx_stat : tx_stat)}, {6'd0, nv}, {tag, " status R7"});
    if (chg_pend) begin
      wr(1'b1, 8'h01);
      chk({7'd0, chg_pend}, 8'd0, {tag, " clear R6"});
    end
  endtask

  task automatic park(input logic [7:0] ien);
    wr(1'b0, 8'h00);
    step(0, 2'b00, 0, "park tx");
    step(1, 2'b00, 0, "park rx");
    wr(1'b0, ien);
  endtask

  task automatic t_reset;
    chk(ien_rd, 8'h00, "reset ien R10");
    chk({chg_pend, chg_irq, ovr_irq, rxf_irq}, 8'h00, "reset flags R6");
    chk({4'd0, tx_stat, rx_stat}, 8'h00, "reset status R7");
  endtask

  task automatic t_code00;
    park(8'h00);
    step(0, 2'b01, 0, "R1 00->01");
    step(0, 2'b11, 0, "R1 01->11");
    step(0, 2'b00, 0, "R1 11->00");
  endtask

  task automatic t_code01;
    park(8'h04);
    step(0, 2'b01, 0, "R2 00->01");
    step(0, 2'b10, 0, "R2 01->10");
    step(0, 2'b11, 1, "R2 10->11");
    step(0, 2'b10, 1, "R2 11->10");
    step(0, 2'b00, 0, "R2 10->00");
  endtask

  task automatic t_code10;
    park(8'h08);
    step(0, 2'b10, 0, "R3 00->10");
    step(0, 2'b01, 1, "R3 10->01");
    step(0, 2'b00, 1, "R3 01->00");
    step(0, 2'b10, 0, "R3 00->10b");
    step(0, 2'b11, 1, "R3 10->11");
    step(0, 2'b00, 1, "R3 11->00");
  endtask

  task automatic t_code11;
    park(8'h0C);
    step(0, 2'b01, 1, "R4 00->01");
    step(0, 2'b10, 1, "R4 01->10");
    step(0, 2'b00, 1, "R4 10->00");
    step(0, 2'b00, 0, "R4 no change");
  endtask

  task automatic t_rx;
    park(8'h10);
    step(1, 2'b11, 1, "R5 rx 00->11");
    step(0, 2'b11, 0, "R5 tx ignored");
    step(1, 2'b01, 1, "R5 rx 11->01");
    park(8'h0C);
    step(1, 2'b10, 0, "R5 rx ignored by tx code");
  endtask

  task automatic t_freeze;
    park(8'h0C);
    step(0, 2'b00, 0, "R7 idle");
    @(negedge clk); tx_state = 2'b01;
    @(negedge clk);
    chk({7'd0, chg_pend}, 8'd1, "R6 set");
    chk({6'd0, tx_stat}, 8'd1, "R7 captured");
    tx_state = 2'b11;
    @(negedge clk);
    chk({6'd0, tx_stat}, 8'd1, "R7 frozen");
    wr(1'b1, 8'h00);
    chk({7'd0, chg_pend}, 8'd1, "R6 write 0 ignored");
    wr(1'b1, 8'h01);
    chk({7'd0, chg_pend}, 8'd0, "R6 cleared");
    chk({6'd0, tx_stat}, 8'd1, "R7 held through clear edge");
    @(negedge clk);
    chk({6'd0, tx_stat}, 8'd3, "R7 catches up");
  endtask

  task automatic t_set_wins;
    park(8'h0C);
    @(negedge clk);
    tx_state = 2'b10; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk({7'd0, chg_pend}, 8'd1, "R6 set beats clear");
    wr(1'b1, 8'h01);
  endtask

  task automatic t_gate;
    park(8'h0C);
    step(0, 2'b00, 0, "R8 idle");
    @(negedge clk); tx_state = 2'b01;
    @(negedge clk);
    chk({7'd0, chg_irq}, 8'd0, "R8 masked");
    wr(1'b0, 8'h4C);
    chk({7'd0, chg_irq}, 8'd1, "R8 enabled");
    wr(1'b1, 8'h01);
    chk({7'd0, chg_irq}, 8'd0, "R8 after clear");
    ovr_flag = 1'b1; rxf_flag = 1'b1;
    wr(1'b0, 8'h02);
    chk({6'd0, ovr_irq, rxf_irq}, 8'h02, "R9 ovr only");
    wr(1'b0, 8'h01);
    chk({6'd0, ovr_irq, rxf_irq}, 8'h01, "R9 rxf only");
    wr(1'b0, 8'h00);
    chk({6'd0, ovr_irq, rxf_irq}, 8'h00, "R9 both off");
    ovr_flag = 1'b0; rxf_flag = 1'b0;
  endtask

  task automatic t_init;
    wr(1'b0, 8'h7F);
    chk(ien_rd, 8'h7F, "R10 written");
    @(negedge clk); init_req = 1'b1;
    @(negedge clk);
    chk(ien_rd, 8'h7F, "R10 req alone keeps");
    init_ack = 1'b1;
    @(negedge clk);
    chk(ien_rd, 8'h00, "R10 forced zero");
    wr(1'b0, 8'h15);
    chk(ien_rd, 8'h00, "R10 write ignored");
    init_req = 1'b0; init_ack = 1'b0;
    wr(1'b0, 8'h15);
    chk(ien_rd, 8'h15, "R10 writable again");
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_code00;
    t_code01;
    t_code10;
    t_code11;
    t_rx;
    t_freeze;
    t_set_wins;
    t_gate;
    t_init;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule